// File: doc/BRIEF.md
# Burst-Copy DMA Engine

This engine moves a contiguous block of bytes from one memory location to another. A register front end presents a descriptor: byte count, source address, destination address, separate read and write burst-size fields, and a repeat flag. It also pulses a start strobe. The engine checks the descriptor before any bus activity. A valid descriptor is latched into working registers. The engine then alternates a read burst from the source with a write burst of the same data to the destination until the count reaches zero.

Completion and rejection are reported on two sticky status outputs. The working byte count, source address and destination address are exposed at all times so that software can watch progress. With the repeat flag set, the working registers return to their starting values when a transfer finishes, so the same copy can be launched again without rewriting the descriptor.

The memory port carries one whole burst per request on a bus 64 bytes wide. Burst byte `i` travels on data bits `[8*i+7 : 8*i]`. The request stays high until the memory returns a one-cycle acknowledge.

Top module: `dma_copy_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o` and `mem_req_o` are low, and all three working registers read zero.
- R2: A start with a byte count of zero is rejected: `err_o` goes high two clock edges after the start, `done_o` goes low, no memory request is issued, and the working registers keep their previous values.
- R3: A start whose read-size field differs from its write-size field is rejected in the same way as R2.
- R4: The burst length is 2^e bytes, where e is the write-size field limited to at most 6. `mem_size_o` presents e during every request.
- R5: A start whose byte count is not a whole multiple of the burst length is rejected in the same way as R2.
- R6: An accepted start clears `done_o` and `err_o`, raises `busy_o` on the next edge, and loads the descriptor's count, source and destination into the working registers.
- R7: Each burst is a read request at the working source address, followed by a write request at the working destination address. After the write acknowledge, both addresses advance by the burst length and the count drops by it. A transfer of N bytes therefore issues exactly N / 2^e reads and N / 2^e writes.
- R8: One edge after the final write acknowledge, `busy_o` falls and `done_o` rises. Without repeat, the working count reads zero and each address reads its start value plus N.
- R9: With repeat set, the working count, source and destination read the descriptor values captured at start once the transfer completes.
- R10: A start strobe while the engine is not idle, including the cycle in which it finishes, is ignored.
- R11: The bytes written to the destination equal the bytes read from the source, in order, and no byte beyond the block is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch strobe |
| repeat_i | input | 1 | Rearm working registers at completion |
| rd_size_i | input | 4 | log2 of read burst size |
| wr_size_i | input | 4 | log2 of write burst size |
| bytes_i | input | BYTES_W | Byte count of the block |
| src_i | input | ADDR_W | Source start address |
| dst_i | input | ADDR_W | Destination start address |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Sticky completion status |
| err_o | output | 1 | Sticky rejection status |
| exec_bytes_o | output | BYTES_W | Working remaining count |
| exec_src_o | output | ADDR_W | Working source address |
| exec_dst_o | output | ADDR_W | Working destination address |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write burst, 0 = read burst |
| mem_addr_o | output | ADDR_W | Burst start address |
| mem_size_o | output | LOG2_W | log2 of burst length |
| mem_wdata_o | output | DATA_W | Write burst data |
| mem_ack_i | input | 1 | One-cycle acknowledge |
| mem_rdata_i | input | DATA_W | Read burst data, valid with acknowledge |

## Verification
Two events can land in the same cycle: a new start strobe and the completion of the running transfer, which also performs the repeat reload. The bench provokes this by raising start with a different descriptor during a repeating transfer and holding it through the finishing cycle. It releases the strobe as soon as `busy_o` drops. The result is judged at the ports. The read and write counts must match the first descriptor alone, and the working registers must show the first descriptor's reloaded values. No further request may follow.

// File: rtl/dma_copy_pkg.sv
package dma_copy_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_FIN,
    ST_ERR
  } eng_state_t;

  // Limit a log2 size field to the largest supported burst exponent.
  function automatic int unsigned clamp_log2(input logic [3:0] fld,
                                             input int unsigned cap);
    int unsigned f;
    f = {28'd0, fld};
    return (f > cap) ? cap : f;
  endfunction

endpackage

// File: rtl/dma_desc_check.sv
module dma_desc_check
  import dma_copy_pkg::*;
#(
  parameter int BYTES_W  = 32,
  parameter int MAX_LOG2 = 6,
  parameter int LOG2_W   = 3
) (
  input  logic [BYTES_W-1:0] bytes_i,
  input  logic [3:0]         rd_size_i,
  input  logic [3:0]         wr_size_i,
  output logic               ok_o,
  output logic [LOG2_W-1:0]  eff_o
);
  int unsigned        e;
  logic [BYTES_W-1:0] mask;

  always_comb begin
    e     = clamp_log2(wr_size_i, MAX_LOG2);
    eff_o = LOG2_W'(e);
    mask  = (BYTES_W'(1) << e) - BYTES_W'(1);
    ok_o  = (bytes_i != '0) && (rd_size_i == wr_size_i) && ((bytes_i & mask) == '0);
  end
endmodule

// File: rtl/dma_exec_regs.sv
module dma_exec_regs #(
  parameter int ADDR_W  = 32,
  parameter int BYTES_W = 32,
  parameter int LOG2_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               step_i,
  input  logic               reload_i,
  input  logic [BYTES_W-1:0] bytes_i,
  input  logic [ADDR_W-1:0]  src_i,
  input  logic [ADDR_W-1:0]  dst_i,
  input  logic [LOG2_W-1:0]  eff_i,
  output logic [BYTES_W-1:0] bytes_o,
  output logic [ADDR_W-1:0]  src_o,
  output logic [ADDR_W-1:0]  dst_o,
  output logic [LOG2_W-1:0]  eff_o,
  output logic               last_o
);
  logic [BYTES_W-1:0] save_bytes;
  logic [ADDR_W-1:0]  save_src, save_dst;
  logic [BYTES_W-1:0] step_bytes;
  logic [ADDR_W-1:0]  step_addr;

  assign step_bytes = BYTES_W'(1) << eff_o;
  assign step_addr  = ADDR_W'(1) << eff_o;
  assign last_o     = (bytes_o == step_bytes);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_o    <= '0;
      src_o      <= '0;
      dst_o      <= '0;
      eff_o      <= '0;
      save_bytes <= '0;
      save_src   <= '0;
      save_dst   <= '0;
    end else if (load_i) begin
      bytes_o    <= bytes_i;
      src_o      <= src_i;
      dst_o      <= dst_i;
      eff_o      <= eff_i;
      save_bytes <= bytes_i;
      save_src   <= src_i;
      save_dst   <= dst_i;
    end else if (step_i) begin
      bytes_o <= bytes_o - step_bytes;
      src_o   <= src_o + step_addr;
      dst_o   <= dst_o + step_addr;
    end else if (reload_i) begin
      bytes_o <= save_bytes;
      src_o   <= save_src;
      dst_o   <= save_dst;
    end
  end
endmodule

// File: rtl/dma_burst_buf.sv
module dma_burst_buf #(
  parameter int DATA_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end
endmodule

// File: rtl/dma_copy_engine.sv
module dma_copy_engine
  import dma_copy_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BYTES_W  = 32,
  parameter int MAX_LOG2 = 6,
  localparam int DATA_W  = 8 << MAX_LOG2,
  localparam int LOG2_W  = $clog2(MAX_LOG2 + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               repeat_i,
  input  logic [3:0]         rd_size_i,
  input  logic [3:0]         wr_size_i,
  input  logic [BYTES_W-1:0] bytes_i,
  input  logic [ADDR_W-1:0]  src_i,
  input  logic [ADDR_W-1:0]  dst_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic [BYTES_W-1:0] exec_bytes_o,
  output logic [ADDR_W-1:0]  exec_src_o,
  output logic [ADDR_W-1:0]  exec_dst_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [LOG2_W-1:0]  mem_size_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic               mem_ack_i,
  input  logic [DATA_W-1:0]  mem_rdata_i
);
  eng_state_t        st_q, st_d;
  logic              desc_ok;
  logic [LOG2_W-1:0] desc_eff;
  logic              last_burst;
  logic              rep_q;

  // Named internal events, observed by the bound checker.
  logic start_ok, start_bad, rd_fire, wr_fire, rearm;

  assign start_ok  = (st_q == ST_IDLE) && start_i && desc_ok;
  assign start_bad = (st_q == ST_IDLE) && start_i && !desc_ok;
  assign rd_fire   = (st_q == ST_RD) && mem_ack_i;
  assign wr_fire   = (st_q == ST_WR) && mem_ack_i;
  assign rearm     = (st_q == ST_FIN) && rep_q;

  dma_desc_check #(.BYTES_W(BYTES_W), .MAX_LOG2(MAX_LOG2), .LOG2_W(LOG2_W)) u_check (
    .bytes_i   (bytes_i),
    .rd_size_i (rd_size_i),
    .wr_size_i (wr_size_i),
    .ok_o      (desc_ok),
    .eff_o     (desc_eff)
  );

  dma_exec_regs #(.ADDR_W(ADDR_W), .BYTES_W(BYTES_W), .LOG2_W(LOG2_W)) u_exec (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (start_ok),
    .step_i   (wr_fire),
    .reload_i (rearm),
    .bytes_i  (bytes_i),
    .src_i    (src_i),
    .dst_i    (dst_i),
    .eff_i    (desc_eff),
    .bytes_o  (exec_bytes_o),
    .src_o    (exec_src_o),
    .dst_o    (exec_dst_o),
    .eff_o    (mem_size_o),
    .last_o   (last_burst)
  );

  dma_burst_buf #(.DATA_W(DATA_W)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .cap_i (rd_fire),
    .d_i   (mem_rdata_i),
    .q_o   (mem_wdata_o)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_ok) st_d = ST_RD; else if (start_bad) st_d = ST_ERR;
      ST_RD:   if (mem_ack_i) st_d = ST_WR;
      ST_WR:   if (mem_ack_i) st_d = last_burst ? ST_FIN : ST_RD;
      ST_FIN:  st_d = ST_IDLE;
      ST_ERR:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rep_q  <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start_ok) begin
        rep_q  <= repeat_i;
        done_o <= 1'b0;
        err_o  <= 1'b0;
      end else if (st_q == ST_FIN) begin
        done_o <= 1'b1;
      end else if (st_q == ST_ERR) begin
        done_o <= 1'b0;
        err_o  <= 1'b1;
      end
    end
  end

  assign busy_o     = (st_q == ST_RD) || (st_q == ST_WR) || (st_q == ST_FIN);
  assign mem_req_o  = (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_we_o   = (st_q == ST_WR);
  assign mem_addr_o = (st_q == ST_WR) ? exec_dst_o : exec_src_o;
endmodule

// File: rtl/dma_copy_chk.sv
module dma_copy_chk #(
  parameter int BYTES_W  = 32,
  parameter int MAX_LOG2 = 6,
  parameter int LOG2_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic               err_o,
  input logic               mem_req_o,
  input logic               mem_we_o,
  input logic               mem_ack_i,
  input logic [LOG2_W-1:0]  mem_size_o,
  input logic [BYTES_W-1:0] exec_bytes_o,
  input logic               start_ok,
  input logic               wr_fire
);
  // R7
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o && mem_ack_i) |=> (mem_req_o && mem_we_o));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> exec_bytes_o == $past(exec_bytes_o) - (BYTES_W'(1) << $past(mem_size_o)));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !busy_o);

  // R2
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (!mem_req_o && !busy_o));

  // R6
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (busy_o && !done_o && !err_o));

  // R4
  size_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (int'(mem_size_o) <= MAX_LOG2));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || done_o));

  // R8
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, err_o}));
endmodule

bind dma_copy_engine dma_copy_chk #(.BYTES_W(BYTES_W), .MAX_LOG2(MAX_LOG2), .LOG2_W(LOG2_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_ack_i    (mem_ack_i),
  .mem_size_o   (mem_size_o),
  .exec_bytes_o (exec_bytes_o),
  .start_ok     (start_ok),
  .wr_fire      (wr_fire)
);

// File: tb/tb_dma_copy_engine.sv
module tb_dma_copy_engine;
  localparam int AW = 32;
  localparam int BW = 32;
  localparam int ML = 6;
  localparam int DW = 8 << ML;
  localparam int LW = $clog2(ML + 1);
  localparam int MEMSZ = 4096;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, rep = 1'b0;
  logic [3:0]    rdsz = '0, wrsz = '0;
  logic [BW-1:0] nbytes = '0;
  logic [AW-1:0] src = '0, dst = '0;
  logic          busy, done, err;
  logic [BW-1:0] xbytes;
  logic [AW-1:0] xsrc, xdst;
  logic          mreq, mwe;
  logic [AW-1:0] maddr;
  logic [LW-1:0] msize;
  logic [DW-1:0] mwdata;
  logic          mack = 1'b0;
  logic [DW-1:0] mrdata = '0;

  logic [7:0] mem [MEMSZ];
  int n_chk = 0, n_fail = 0, cyc = 0;
  int rd_cnt = 0, wr_cnt = 0;
  longint unsigned exp_src = 0, exp_dst = 0;
  int exp_log = 0;

  dma_copy_engine #(.ADDR_W(AW), .BYTES_W(BW), .MAX_LOG2(ML)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .repeat_i(rep),
    .rd_size_i(rdsz), .wr_size_i(wrsz), .bytes_i(nbytes), .src_i(src), .dst_i(dst),
    .busy_o(busy), .done_o(done), .err_o(err),
    .exec_bytes_o(xbytes), .exec_src_o(xsrc), .exec_dst_o(xdst),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_size_o(msize),
    .mem_wdata_o(mwdata), .mem_ack_i(mack), .mem_rdata_i(mrdata)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint unsigned act,
                     input longint unsigned expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Memory model: acknowledges each request one cycle after it appears.
  always @(negedge clk) begin
    if (mack) begin
      mack = 1'b0;
    end else if (mreq && rst_n) begin
      int sz;
      sz = 1 << msize;
      chk(int'(msize) == exp_log, "R4 burst size", longint'(msize), longint'(exp_log));
      if (mwe) begin
        chk(longint'(maddr) == exp_dst, "R7 write address", longint'(maddr), exp_dst);
        for (int i = 0; i < sz; i++) mem[(int'(maddr) + i) % MEMSZ] = mwdata[8*i +: 8];
        exp_src += longint'(sz);
        exp_dst += longint'(sz);
        wr_cnt++;
      end else begin
        chk(longint'(maddr) == exp_src, "R7 read address", longint'(maddr), exp_src);
        mrdata = '0;
        for (int i = 0; i < sz; i++) mrdata[8*i +: 8] = mem[(int'(maddr) + i) % MEMSZ];
        rd_cnt++;
      end
      mack = 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic int eff_of(input int f);
    return (f > ML) ? ML : f;
  endfunction

  task automatic launch(input bit r, input int rs, input int ws, input int nb,
                        input int s, input int d);
    @(negedge clk);
    rep = r; rdsz = 4'(rs); wrsz = 4'(ws); nbytes = BW'(nb); src = AW'(s); dst = AW'(d);
    exp_src = longint'(s); exp_dst = longint'(d); exp_log = eff_of(ws);
    rd_cnt = 0; wr_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 2000 && busy; g++) @(negedge clk);
  endtask

  task automatic prep_mem(input int s, input int d, input int nb);
    for (int i = 0; i < MEMSZ; i++) mem[i] = 8'(i * 13 + 5);
    for (int i = 0; i < nb + 64; i++) mem[(d + i) % MEMSZ] = 8'hEE;
    s = s;
  endtask

  task automatic good_run(input bit r, input int ws, input int nb, input int s, input int d);
    int bad;
    prep_mem(s, d, nb);
    launch(r, ws, ws, nb, s, d);
    chk(busy && !done && !err, "R6 start status", {busy, done, err}, 3'b100);
    chk(xbytes == BW'(nb), "R6 count load", xbytes, nb);
    chk(xsrc == AW'(s) && xdst == AW'(d), "R6 address load", xsrc, s);
    wait_idle();
    chk(done && !err && !busy, "R8 done status", {busy, done, err}, 3'b010);
    chk(wr_cnt == nb >> eff_of(ws) && rd_cnt == wr_cnt, "R7 burst count",
        wr_cnt, nb >> eff_of(ws));
    if (r) begin
      chk(xbytes == BW'(nb) && xsrc == AW'(s) && xdst == AW'(d), "R9 rearm",
          xbytes, nb);
    end else begin
      chk(xbytes == '0, "R8 final count", xbytes, 0);
      chk(xsrc == AW'(s + nb) && xdst == AW'(d + nb), "R8 final address", xdst, d + nb);
    end
    bad = 0;
    for (int i = 0; i < nb; i++) if (mem[d + i] != 8'((s + i) * 13 + 5)) bad++;
    chk(bad == 0, "R11 copied data", bad, 0);
    chk(mem[d + nb] == 8'hEE, "R11 no overrun", mem[d + nb], 8'hEE);
  endtask

  task automatic bad_run(input int rs, input int ws, input int nb, input string tag);
    logic [BW-1:0] pb;
    logic [AW-1:0] ps;
    pb = xbytes; ps = xsrc;
    launch(1'b0, rs, ws, nb, 16, 3000);
    @(negedge clk);
    chk(err && !done && !busy, {tag, " error status"}, {busy, done, err}, 3'b001);
    chk(rd_cnt == 0 && wr_cnt == 0, {tag, " no request"}, rd_cnt + wr_cnt, 0);
    chk(xbytes == pb && xsrc == ps, {tag, " working regs kept"}, xbytes, pb);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !err && !mreq, "R1 reset status", {busy, done, err, mreq}, 0);
    chk(xbytes == '0 && xsrc == '0 && xdst == '0, "R1 reset working regs", xsrc, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R7 R8 R9 R11: sweep size fields 0..7 and 1..3 bursts
    for (int sz = 0; sz < 8; sz++) begin
      for (int k = 1; k <= 3; k++) begin
        good_run(k == 2, sz, (1 << eff_of(sz)) * k, 64 + sz * 8 + k, 2048);
      end
    end

    // R2 zero count, R3 size mismatch, R5 non-multiple
    bad_run(3, 3, 0, "R2");
    bad_run(2, 3, 32, "R3");
    bad_run(2, 2, 6, "R5");
    bad_run(7, 7, 96, "R5 capped");
    // R6 a good start clears a pending error
    good_run(1'b0, 1, 10, 200, 1024);

    // R10 start held through a repeating transfer and its finishing cycle
    prep_mem(100, 1500, 128);
    launch(1'b1, 3, 3, 128, 100, 1500);
    rdsz = 4'd0; wrsz = 4'd0; nbytes = BW'(4); src = AW'(8); dst = AW'(12);
    start = 1'b1;
    for (int g = 0; g < 2000 && busy; g++) @(negedge clk);
    start = 1'b0;
    chk(wr_cnt == 16 && rd_cnt == 16, "R10 only first transfer ran", wr_cnt, 16);
    chk(xbytes == BW'(128) && xsrc == AW'(100) && xdst == AW'(1500),
        "R10 R9 rearm at completion", xdst, 1500);
    repeat (5) @(negedge clk);
    chk(wr_cnt == 16 && !busy && done, "R10 no late start", wr_cnt, 16);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule